// File: doc/BRIEF.md
# Indirect Command/Status Bus Bridge

This block lets a host that only sees a small window of 64-bit registers carry out single 32-bit reads and writes on an internal peripheral bus with 32-bit addresses. The host first loads a data register if it wants to write. It then writes a packed control word that holds a direction flag, a transfer size and a target address. That control write launches exactly one transaction on a request/ready/error master port.

When the transaction completes, the bridge posts a status word. The status word holds a done flag and, for reads, the returned data at a fixed bit offset. The host polls the status register. Every read of that register returns the current word and then clears it. A read that fails on the internal bus still reports done, with all-ones data in the data field.

Top module: `ibr_bridge`

## Requirements
- R1: After a synchronous reset the status word reads zero, the data register reads zero and `m_req` is low.
- R2: Only bits [4:3] of `hst_addr` select a register: 0 control, 1 reserved, 2 status, 3 data. Higher address bits are ignored. An access with `hst_full` low (not an 8-byte access) changes nothing and reads back zero.
- R3: A control write while idle raises `m_req` on the next cycle. It presents `m_wr` as the inverse of control bit 48, `m_size` from control bits [59:56] and `m_addr` from control bits [31:0]. All of these stay stable until `m_ready` is seen.
- R4: For a write transaction, `m_wdata` is bits [63:32] of the data register, with the first (most significant) byte on `m_wdata[31:24]`.
- R5: A read that completes without error sets status bit 11 and places `m_rdata` at status bits [57:26]. All other bits are zero.
- R6: A read that completes with `m_err` high sets status bit 11 and all ones at bits [57:26].
- R7: A write completion sets status to bit 11 alone, whatever `m_err` is.
- R8: A status read returns the current word, and the word is zero afterwards.
- R9: A data register read returns the stored 32-bit value in bits [63:32] with zeros below. The reserved index reads zero, and writes to it are ignored.
- R10: A control write while a transaction is outstanding is ignored. No second transaction runs, and the status word stays unchanged until the outstanding one completes.
- R11: Every host read produces `hst_rvalid` for one cycle, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_full | input | 1 | Access is a full 8-byte access |
| hst_addr | input | HADDR_W | Host byte address |
| hst_wdata | input | 64 | Host write data |
| hst_rvalid | output | 1 | Read data valid |
| hst_rdata | output | 64 | Read data |
| m_req | output | 1 | Internal bus request |
| m_wr | output | 1 | Internal bus direction, 1 = write |
| m_size | output | 4 | Transfer size code |
| m_addr | output | 32 | Internal bus address |
| m_wdata | output | 32 | Internal bus write data |
| m_ready | input | 1 | Transaction complete |
| m_err | input | 1 | Transaction failed (valid with m_ready) |
| m_rdata | input | 32 | Read data (valid with m_ready) |

## Verification
The assertions assume that a host strobe lasts one cycle and that `m_ready` is raised only while `m_req` is high. They also assume that `m_err` and `m_rdata` are meaningful only together with `m_ready`. The stimulus raises ready only from a slave model that watches `m_req` and drops it the cycle after the handshake. Host accesses are one-cycle pulses. The bench never reads status in the same cycle as a completion, because it waits until `m_req` has fallen before polling.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned BUS_AW     = 32;
  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned SZ_W       = 4;
  localparam int unsigned RD_FLAG    = 48;
  localparam int unsigned SZ_LSB     = 56;
  localparam int unsigned DONE_BIT   = 11;
  localparam int unsigned RDATA_LSB  = 26;
  localparam int unsigned DATA_LSB   = 32;
  localparam int unsigned IDX_LSB    = 3;

  typedef enum logic [1:0] {
    IX_CTRL = 2'd0,
    IX_RSVD = 2'd1,
    IX_STAT = 2'd2,
    IX_DATA = 2'd3
  } reg_ix_e;
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
#(
  parameter int unsigned HADDR_W = 16
) (
  input  logic               hst_req,
  input  logic               hst_wr,
  input  logic               hst_full,
  input  logic [HADDR_W-1:0] hst_addr,
  output reg_ix_e            idx,
  output logic               rd_stb,
  output logic               ok_acc,
  output logic               ctl_wr,
  output logic               dat_wr,
  output logic               stat_rd
);
  always_comb begin
    idx     = reg_ix_e'(hst_addr[IDX_LSB +: 2]);
    rd_stb  = hst_req && !hst_wr;
    ok_acc  = hst_req && hst_full;
    ctl_wr  = ok_acc && hst_wr && (idx == IX_CTRL);
    dat_wr  = ok_acc && hst_wr && (idx == IX_DATA);
    stat_rd = ok_acc && !hst_wr && (idx == IX_STAT);
  end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [BUS_DW-1:0] data_hi,
  output logic              m_req,
  output logic              m_wr,
  output logic [SZ_W-1:0]   m_size,
  output logic [BUS_AW-1:0] m_addr,
  output logic [BUS_DW-1:0] m_wdata,
  input  logic              m_ready,
  output logic              done_p,
  output logic              done_rd
);
  logic launch;
  assign launch  = ctl_wr && !m_req;
  assign done_p  = m_req && m_ready;
  assign done_rd = !m_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_req   <= 1'b0;
      m_wr    <= 1'b0;
      m_size  <= '0;
      m_addr  <= '0;
      m_wdata <= '0;
    end else if (m_req) begin
      if (m_ready) m_req <= 1'b0;
    end else if (launch) begin
      m_req   <= 1'b1;
      m_wr    <= !ctl_word[RD_FLAG];
      m_size  <= ctl_word[SZ_LSB +: SZ_W];
      m_addr  <= ctl_word[BUS_AW-1:0];
      m_wdata <= data_hi;
    end
  end
endmodule

// File: rtl/ibr_status.sv
module ibr_status
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done_p,
  input  logic              done_rd,
  input  logic              m_err,
  input  logic [BUS_DW-1:0] m_rdata,
  input  logic              stat_rd,
  output logic [WORD_W-1:0] stat_q
);
  logic [WORD_W-1:0] post;

  always_comb begin
    post = '0;
    post[DONE_BIT] = 1'b1;
    if (done_rd) post[RDATA_LSB +: BUS_DW] = m_err ? {BUS_DW{1'b1}} : m_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          stat_q <= '0;
    else if (done_p)  stat_q <= post;
    else if (stat_rd) stat_q <= '0;
  end
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned HADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_req,
  input  logic               hst_wr,
  input  logic               hst_full,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [63:0]        hst_wdata,
  output logic               hst_rvalid,
  output logic [63:0]        hst_rdata,
  output logic               m_req,
  output logic               m_wr,
  output logic [3:0]         m_size,
  output logic [31:0]        m_addr,
  output logic [31:0]        m_wdata,
  input  logic               m_ready,
  input  logic               m_err,
  input  logic [31:0]        m_rdata
);
  reg_ix_e           idx;
  logic              rd_stb, ok_acc, ctl_wr, dat_wr, stat_rd;
  logic              done_p, done_rd;
  logic [BUS_DW-1:0] data_q;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] rd_mux;

  ibr_decode #(.HADDR_W(HADDR_W)) u_dec (
    .hst_req(hst_req), .hst_wr(hst_wr), .hst_full(hst_full), .hst_addr(hst_addr),
    .idx(idx), .rd_stb(rd_stb), .ok_acc(ok_acc), .ctl_wr(ctl_wr),
    .dat_wr(dat_wr), .stat_rd(stat_rd)
  );

  ibr_seq u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_word(hst_wdata), .data_hi(data_q),
    .m_req(m_req), .m_wr(m_wr), .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .done_p(done_p), .done_rd(done_rd)
  );

  ibr_status u_stat (
    .clk(clk), .rst(rst), .done_p(done_p), .done_rd(done_rd), .m_err(m_err),
    .m_rdata(m_rdata), .stat_rd(stat_rd), .stat_q(stat_word)
  );

  always_ff @(posedge clk) begin
    if (rst)         data_q <= '0;
    else if (dat_wr) data_q <= hst_wdata[DATA_LSB +: BUS_DW];
  end

  always_comb begin
    rd_mux = '0;
    if (ok_acc) begin
      case (idx)
        IX_STAT: rd_mux = stat_word;
        IX_DATA: rd_mux[DATA_LSB +: BUS_DW] = data_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rvalid <= 1'b0;
      hst_rdata  <= '0;
    end else begin
      hst_rvalid <= rd_stb;
      if (rd_stb) hst_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ibr_chk.sv
module ibr_chk #(
  parameter int unsigned HADDR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               hst_req,
  input logic               hst_wr,
  input logic               hst_full,
  input logic [HADDR_W-1:0] hst_addr,
  input logic               hst_rvalid,
  input logic               m_req,
  input logic               m_wr,
  input logic [31:0]        m_addr,
  input logic [3:0]         m_size,
  input logic               m_ready,
  input logic [63:0]        stat_word
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_wr) && $stable(m_size)));

  assert_launch_src_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(m_req) |-> $past(hst_req && hst_wr && hst_full && hst_addr[4:3] == 2'd0));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    (hst_req && !hst_wr) |=> hst_rvalid);

  assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    !(hst_req && !hst_wr) |=> !hst_rvalid);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (hst_req && !hst_wr && hst_full && hst_addr[4:3] == 2'd2 && !(m_req && m_ready))
      |=> (stat_word == 64'd0));

  assert_wr_done_R7: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ready && m_wr) |=> (stat_word == 64'h800));
endmodule

bind ibr_bridge ibr_chk #(.HADDR_W(HADDR_W)) u_chk (
  .clk(clk), .rst(rst), .hst_req(hst_req), .hst_wr(hst_wr), .hst_full(hst_full),
  .hst_addr(hst_addr), .hst_rvalid(hst_rvalid), .m_req(m_req), .m_wr(m_wr),
  .m_addr(m_addr), .m_size(m_size), .m_ready(m_ready), .stat_word(stat_word)
);

// File: tb/sim_ibr_bridge.sv
`timescale 1ns/1ps
module sim_ibr_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_req = 1'b0, hst_wr = 1'b0, hst_full = 1'b0;
  logic [15:0] hst_addr = '0;
  logic [63:0] hst_wdata = '0;
  logic        hst_rvalid;
  logic [63:0] hst_rdata;
  logic        m_req, m_wr;
  logic [3:0]  m_size;
  logic [31:0] m_addr, m_wdata;
  logic        m_ready = 1'b0, m_err = 1'b0;
  logic [31:0] m_rdata = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  int          sl_delay = 0;
  bit          sl_err = 0;
  logic [31:0] sl_rdata = '0;
  int          sl_cnt = 0;
  int          hs_cnt = 0;
  logic        rec_wr;
  logic [3:0]  rec_size;
  logic [31:0] rec_addr, rec_wdata;

  always #2.5 clk = ~clk;

  ibr_bridge #(.HADDR_W(16)) u0 (
    .clk(clk), .rst(rst), .hst_req(hst_req), .hst_wr(hst_wr), .hst_full(hst_full),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rvalid(hst_rvalid),
    .hst_rdata(hst_rdata), .m_req(m_req), .m_wr(m_wr), .m_size(m_size),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_err(m_err),
    .m_rdata(m_rdata)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // slave model
  always @(negedge clk) begin
    if (rst) begin
      m_ready = 1'b0; sl_cnt = 0;
    end else if (m_ready) begin
      m_ready = 1'b0; sl_cnt = 0;
    end else if (m_req) begin
      if (sl_cnt >= sl_delay) begin
        m_ready = 1'b1; m_err = sl_err; m_rdata = sl_rdata;
        rec_wr = m_wr; rec_size = m_size; rec_addr = m_addr; rec_wdata = m_wdata;
        hs_cnt++;
      end else sl_cnt++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && hst_rvalid) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected rvalid", hst_rdata, '0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(hst_rdata === e, t, hst_rdata, e);
      end
    end
  end

  task automatic host_wr(input logic [15:0] a, input logic [63:0] d, input bit full = 1);
    @(negedge clk);
    hst_req = 1; hst_wr = 1; hst_full = full; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_req = 0; hst_wr = 0; hst_full = 0;
  endtask

  task automatic host_rd(input logic [15:0] a, input logic [63:0] e, input string t, input bit full = 1);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    hst_req = 1; hst_wr = 0; hst_full = full; hst_addr = a;
    @(negedge clk);
    hst_req = 0; hst_full = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_req);
  endtask

  function automatic logic [63:0] ctl(input bit rd, input logic [3:0] sz, input logic [31:0] a);
    logic [63:0] w = '0;
    w[48] = rd; w[59:56] = sz; w[31:0] = a;
    return w;
  endfunction

  function automatic logic [63:0] rdstat(input logic [31:0] d);
    logic [63:0] w = '0;
    w[11] = 1'b1; w[57:26] = d;
    return w;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk(m_req == 0, "R1 m_req after reset", {63'd0, m_req}, 0);
    host_rd(16'h10, 64'd0, "R1 status at reset");
    host_rd(16'h18, 64'd0, "R1 data at reset");

    // R4/R9 data register, write transaction
    host_wr(16'h18, 64'hA1B2C3D4_55667788);
    host_rd(16'h18, 64'hA1B2C3D4_00000000, "R9 data readback");
    sl_delay = 2; sl_err = 0;
    host_wr(16'h00, ctl(0, 4'h4, 32'h1234_5678));
    wait_idle();
    chk(hs_cnt == 1, "R3 one handshake", hs_cnt, 1);
    chk(rec_wr == 1, "R3 write direction", {63'd0, rec_wr}, 1);
    chk(rec_addr == 32'h1234_5678, "R3 address", {32'd0, rec_addr}, 64'h12345678);
    chk(rec_size == 4'h4, "R3 size", {60'd0, rec_size}, 4);
    chk(rec_wdata == 32'hA1B2C3D4, "R4 write data byte order", {32'd0, rec_wdata}, 64'hA1B2C3D4);
    host_rd(16'h10, 64'h800, "R7 write done status");
    host_rd(16'h10, 64'd0, "R8 status cleared");

    // R7 write with error
    sl_err = 1; sl_delay = 0;
    host_wr(16'h00, ctl(0, 4'h1, 32'h0000_00F0));
    wait_idle();
    host_rd(16'h10, 64'h800, "R7 write error status");

    // R5 read
    sl_err = 0; sl_rdata = 32'hDEAD_BEEF; sl_delay = 1;
    host_wr(16'h00, ctl(1, 4'h2, 32'hC001_0000));
    wait_idle();
    chk(rec_wr == 0, "R3 read direction", {63'd0, rec_wr}, 0);
    chk(rec_size == 4'h2, "R3 read size", {60'd0, rec_size}, 2);
    host_rd(16'h10, rdstat(32'hDEAD_BEEF), "R5 read status");
    host_rd(16'h10, 64'd0, "R8 cleared after read");

    // R6 read error
    sl_err = 1; sl_rdata = 32'h0000_1111;
    host_wr(16'h00, ctl(1, 4'h4, 32'h0000_0004));
    wait_idle();
    host_rd(16'h10, rdstat(32'hFFFF_FFFF), "R6 error read all ones");

    // R10 control write while busy
    sl_err = 0; sl_delay = 20;
    hs_cnt = 0;
    host_wr(16'h00, ctl(0, 4'h4, 32'h0000_AAAA));
    host_wr(16'h00, ctl(1, 4'h1, 32'h0000_BBBB));
    host_rd(16'h10, 64'd0, "R10 status unchanged while busy");
    wait_idle();
    repeat (3) @(negedge clk);
    chk(hs_cnt == 1, "R10 single transaction", hs_cnt, 1);
    chk(rec_addr == 32'h0000_AAAA, "R10 first command kept", {32'd0, rec_addr}, 64'hAAAA);
    host_rd(16'h10, 64'h800, "R10 status from first command");

    // R2/R9 reserved, partial access, aliasing
    host_wr(16'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    host_rd(16'h08, 64'd0, "R9 reserved reads zero");
    host_rd(16'h18, 64'hA1B2C3D4_00000000, "R9 reserved write ignored");
    host_wr(16'h18, 64'h0BAD_0BAD_0000_0000, 0);
    host_rd(16'h18, 64'hA1B2C3D4_00000000, "R2 partial write ignored");
    host_rd(16'h18, 64'd0, "R2 partial read zero", 0);
    host_rd(16'h38, 64'hA1B2C3D4_00000000, "R2 upper address bits ignored");
    hs_cnt = 0;
    host_wr(16'h00, ctl(0, 4'h4, 32'h0000_0001), 0);
    repeat (4) @(negedge clk);
    chk(hs_cnt == 0 && m_req == 0, "R2 partial control write ignored", hs_cnt, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule